// File: doc/BRIEF.md
# SPI NOR Flash Target Responder

This block is a synthesizable SPI target that answers like a small serial NOR flash. It is meant as an on-chip partner for an SPI controller: the controller sends opcodes, addresses and data in SPI mode 0, with the most significant bit first. The block keeps a write-enable latch and a busy flag, serves sequential reads, programs bytes within a page and erases whole sectors of an internal byte array.

The SPI pins are oversampled in the system clock domain through a parameterised synchronizer. Bytes are captured on rising serial-clock edges. Response bits are shifted out on falling edges. A page program ANDs each incoming byte into the array as soon as it arrives. Raising chip select then starts a busy window of a programmable length in clock cycles. A sector erase starts a busy window during which the sector is swept to 0xFF, one byte per cycle. While busy, only the status read gets an answer.

Top module: `nf_flash_target`

## Requirements
- R1: After reset the status byte reads 0x00, and spi_miso is low whenever chip select is deasserted.
- R2: Opcode 0x06 sets the write-enable latch. Opcode 0x05 returns the status byte after the opcode, and keeps returning its current value on every further byte while chip select stays low. It is answered at any time, including while busy. Status layout: bit 0 is busy (write in progress), bit 1 is the write-enable latch, and bits 7 to 2 read zero.
- R3: Opcode 0x03 is followed by three address bytes, most significant first. Address bits above the array width are ignored. Data bytes then stream from consecutive addresses for as long as chip select stays low, wrapping from the last array byte to byte 0.
- R4: Opcode 0x02 with three address bytes ANDs each following data byte into the array. The low 8 address bits advance per byte and wrap inside the same 256-byte page, so the upper bits stay fixed.
- R5: Program and erase have no effect on the array or the busy flag when the write-enable latch is clear.
- R6: Opcode 0xD8 with three address bytes sets every byte of the sector that holds the address to 0xFF, and leaves every other sector unchanged.
- R7: A program (chip select raised after at least the three address bytes) sets the busy flag for PROG_CYCLES cycles. An erase sets it for ERASE_CYCLES cycles. The write-enable latch stays set while busy and is clear once the busy flag drops.
- R8: While busy, every opcode other than 0x05 is ignored: a read returns 0x00 bytes, 0x06 does not set the latch, and a program does not change the array.
- R9: Unrecognised opcodes are ignored. Any response bytes are 0x00 and the status is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |

## Verification
Each serial-clock edge takes two synchronizer stages and one edge-detect register to act. A received byte is therefore complete three system clocks after its eighth rising edge. Its response byte is loaded one clock later, and the first response bit appears three clocks after the next falling edge. The bench holds each serial-clock phase for four system clocks, so it always samples spi_miso on a rising edge it has just driven, after the last update. The busy flag rises three clocks after chip select goes high and lasts exactly the configured count; the checker counts this window to the cycle, while the bench counts polled status bytes against the arithmetic bound of ERASE_CYCLES over 64 clocks per byte. Array contents are checked against a byte model that applies the page wrap, the AND and the sector fill.

// File: rtl/nf_pkg.sv
package nf_pkg;
   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_PROG  = 8'h02;
   localparam logic [7:0] OP_ERASE = 8'hD8;

   typedef enum logic [2:0] {
      CMD_NONE, CMD_WREN, CMD_RDSR, CMD_READ, CMD_PROG, CMD_ERASE
   } cmd_e;

   typedef enum logic [1:0] {JOB_IDLE, JOB_PROG, JOB_ERASE} job_e;

   function automatic cmd_e decode_op(input logic [7:0] op);
      case (op)
         OP_WREN:  return CMD_WREN;
         OP_RDSR:  return CMD_RDSR;
         OP_READ:  return CMD_READ;
         OP_PROG:  return CMD_PROG;
         OP_ERASE: return CMD_ERASE;
         default:  return CMD_NONE;
      endcase
   endfunction
endpackage

// File: rtl/nf_spi_front.sv
module nf_spi_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sck,
   input  logic       spi_cs_n,
   input  logic       spi_mosi,
   input  logic       tx_load,
   input  logic [7:0] tx_byte,
   output logic       byte_valid,
   output logic [7:0] rx_byte,
   output logic       sel,
   output logic       cs_rise,
   output logic       miso
);
   // pin order inside one stage: {sck, cs_n, mosi}
   logic [SYNC_STAGES-1:0][2:0] stg;
   logic [2:0] pins_s;
   logic       prev_sck, prev_cs;
   logic       sck_rise, sck_fall;
   logic [6:0] rx_sr;
   logic [2:0] bitc;
   logic [7:0] tx_sr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= 3'b010;
      end else begin
         for (int i = SYNC_STAGES - 1; i > 0; i--) stg[i] <= stg[i-1];
         stg[0] <= {spi_sck, spi_cs_n, spi_mosi};
      end
   end

   assign pins_s   = stg[SYNC_STAGES-1];
   assign sel      = ~pins_s[1];
   assign cs_rise  = pins_s[1] & ~prev_cs;
   assign sck_rise = pins_s[2] & ~prev_sck;
   assign sck_fall = ~pins_s[2] & prev_sck;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_sck   <= 1'b0;
         prev_cs    <= 1'b1;
         rx_sr      <= '0;
         bitc       <= '0;
         byte_valid <= 1'b0;
         rx_byte    <= '0;
      end else begin
         prev_sck   <= pins_s[2];
         prev_cs    <= pins_s[1];
         byte_valid <= 1'b0;
         if (!sel) begin
            bitc <= '0;
         end else if (sck_rise) begin
            rx_sr <= {rx_sr[5:0], pins_s[0]};
            bitc  <= bitc + 3'd1;
            if (bitc == 3'd7) begin
               byte_valid <= 1'b1;
               rx_byte    <= {rx_sr, pins_s[0]};
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_sr <= '0;
         miso  <= 1'b0;
      end else if (!sel) begin
         tx_sr <= '0;
         miso  <= 1'b0;
      end else if (tx_load) begin
         tx_sr <= tx_byte;
      end else if (sck_fall) begin
         miso  <= tx_sr[7];
         tx_sr <= {tx_sr[6:0], 1'b0};
      end
   end
endmodule

// File: rtl/nf_mem_array.sv
module nf_mem_array #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              we,
   input  logic              wand_mode,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wand_mode ? (mem[waddr] & wdata) : wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/nf_cmd_ctrl.sv
module nf_cmd_ctrl
   import nf_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int PAGE_BYTES   = 256,
   parameter int SECTOR_BYTES = 1024,
   parameter int PROG_CYCLES  = 400,
   parameter int ERASE_CYCLES = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid,
   input  logic [7:0]        rx_byte,
   input  logic              sel,
   input  logic              cs_rise,
   input  logic [7:0]        rd_data,
   output logic              tx_load,
   output logic [7:0]        tx_byte,
   output logic              mem_we,
   output logic              mem_and,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [7:0]        mem_wdata,
   output logic [ADDR_W-1:0] mem_raddr,
   output logic              wip,
   output logic              wel
);
   localparam int COL_W   = $clog2(PAGE_BYTES);
   localparam int SECT_W  = $clog2(SECTOR_BYTES);
   localparam int BASE_W  = ADDR_W - SECT_W;
   localparam int MAXBUSY = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int CNT_W   = $clog2(MAXBUSY + 1);

   cmd_e              cmd, cmd_in;
   job_e              job;
   logic [2:0]        bcnt;
   logic [23:0]       addr_sh, addr_next;
   logic [ADDR_W-1:0] rd_ptr, wr_ptr;
   logic [CNT_W-1:0]  busy_cnt;
   logic [SECT_W:0]   ers_idx;
   logic [BASE_W-1:0] ers_base;
   logic [7:0]        status_byte;
   logic              unused_addr_hi;

   assign addr_next      = {addr_sh[15:0], rx_byte};
   assign unused_addr_hi = ^addr_sh[23:ADDR_W];
   assign status_byte    = {6'b0, wel, wip};
   assign cmd_in         = (wip && decode_op(rx_byte) != CMD_RDSR) ? CMD_NONE
                                                                   : decode_op(rx_byte);
   assign mem_raddr      = (bcnt == 3'd3) ? addr_next[ADDR_W-1:0] : rd_ptr;

   always_comb begin
      tx_load = 1'b0;
      tx_byte = 8'h00;
      if (byte_valid) begin
         if ((bcnt == 3'd0 && cmd_in == CMD_RDSR) || (bcnt != 3'd0 && cmd == CMD_RDSR)) begin
            tx_load = 1'b1;
            tx_byte = status_byte;
         end else if (cmd == CMD_READ && bcnt >= 3'd3) begin
            tx_load = 1'b1;
            tx_byte = rd_data;
         end
      end
   end

   always_comb begin
      mem_we    = 1'b0;
      mem_and   = 1'b0;
      mem_waddr = wr_ptr;
      mem_wdata = rx_byte;
      if (wip && job == JOB_ERASE && !ers_idx[SECT_W]) begin
         mem_we    = 1'b1;
         mem_waddr = {ers_base, ers_idx[SECT_W-1:0]};
         mem_wdata = 8'hFF;
      end else if (byte_valid && sel && cmd == CMD_PROG && wel && bcnt == 3'd4) begin
         mem_we  = 1'b1;
         mem_and = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd      <= CMD_NONE;
         job      <= JOB_IDLE;
         bcnt     <= '0;
         addr_sh  <= '0;
         rd_ptr   <= '0;
         wr_ptr   <= '0;
         busy_cnt <= '0;
         ers_idx  <= '0;
         ers_base <= '0;
         wip      <= 1'b0;
         wel      <= 1'b0;
      end else begin
         if (cs_rise) begin
            if (wel && bcnt == 3'd4 && cmd == CMD_PROG) begin
               wip      <= 1'b1;
               job      <= JOB_PROG;
               busy_cnt <= CNT_W'(PROG_CYCLES - 1);
            end else if (wel && bcnt == 3'd4 && cmd == CMD_ERASE) begin
               wip      <= 1'b1;
               job      <= JOB_ERASE;
               busy_cnt <= CNT_W'(ERASE_CYCLES - 1);
               ers_idx  <= '0;
               ers_base <= addr_sh[ADDR_W-1:SECT_W];
            end
            cmd  <= CMD_NONE;
            bcnt <= '0;
         end else if (!sel) begin
            cmd  <= CMD_NONE;
            bcnt <= '0;
         end else if (byte_valid) begin
            if (bcnt != 3'd4) bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd0) begin
               cmd <= cmd_in;
               if (cmd_in == CMD_WREN) wel <= 1'b1;
            end
            if (bcnt >= 3'd1 && bcnt <= 3'd3) addr_sh <= addr_next;
            if (bcnt == 3'd3) begin
               rd_ptr <= addr_next[ADDR_W-1:0] + ADDR_W'(1);
               wr_ptr <= addr_next[ADDR_W-1:0];
            end
            if (bcnt == 3'd4 && cmd == CMD_READ) rd_ptr <= rd_ptr + ADDR_W'(1);
            if (bcnt == 3'd4 && cmd == CMD_PROG)
               wr_ptr <= {wr_ptr[ADDR_W-1:COL_W], wr_ptr[COL_W-1:0] + COL_W'(1)};
         end

         if (wip) begin
            if (job == JOB_ERASE && !ers_idx[SECT_W]) ers_idx <= ers_idx + (SECT_W+1)'(1);
            if (busy_cnt == '0) begin
               wip <= 1'b0;
               wel <= 1'b0;
               job <= JOB_IDLE;
            end else begin
               busy_cnt <= busy_cnt - CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/nf_flash_target.sv
module nf_flash_target #(
   parameter int ADDR_W       = 11,
   parameter int PAGE_BYTES   = 256,
   parameter int SECTOR_BYTES = 1024,
   parameter int PROG_CYCLES  = 400,
   parameter int ERASE_CYCLES = 2000,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_cs_n,
   input  logic spi_mosi,
   output logic spi_miso
);
   localparam int COL_W  = $clog2(PAGE_BYTES);
   localparam int SECT_W = $clog2(SECTOR_BYTES);

   generate
      if (PAGE_BYTES != (1 << COL_W) || SECTOR_BYTES != (1 << SECT_W))
         begin : g_bad_pow2
            $error("page and sector sizes must be powers of two");
         end
      if (SECT_W < COL_W || SECT_W >= ADDR_W || ADDR_W > 23)
         begin : g_bad_geom
            $error("need page <= sector < array, array address under 24 bits");
         end
      if (ERASE_CYCLES < SECTOR_BYTES || PROG_CYCLES < 1)
         begin : g_bad_busy
            $error("erase time must cover one cycle per sector byte");
         end
      if (SYNC_STAGES < 2)
         begin : g_bad_sync
            $error("at least two synchronizer stages are required");
         end
   endgenerate

   logic              f_valid, f_sel, f_rise, tx_load;
   logic [7:0]        f_byte, tx_byte, rd_data, m_wdata;
   logic              m_we, m_and, st_wip, st_wel;
   logic [ADDR_W-1:0] m_waddr, m_raddr;

   nf_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .tx_load(tx_load), .tx_byte(tx_byte),
      .byte_valid(f_valid), .rx_byte(f_byte), .sel(f_sel),
      .cs_rise(f_rise), .miso(spi_miso)
   );

   nf_cmd_ctrl #(
      .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
      .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .byte_valid(f_valid), .rx_byte(f_byte), .sel(f_sel), .cs_rise(f_rise),
      .rd_data(rd_data), .tx_load(tx_load), .tx_byte(tx_byte),
      .mem_we(m_we), .mem_and(m_and), .mem_waddr(m_waddr), .mem_wdata(m_wdata),
      .mem_raddr(m_raddr), .wip(st_wip), .wel(st_wel)
   );

   nf_mem_array #(.ADDR_W(ADDR_W)) u_mem (
      .clk(clk), .we(m_we), .wand_mode(m_and), .waddr(m_waddr),
      .wdata(m_wdata), .raddr(m_raddr), .rdata(rd_data)
   );
endmodule

// File: rtl/nf_flash_target_chk.sv
module nf_flash_target_chk #(
   parameter int PROG_CYCLES  = 400,
   parameter int ERASE_CYCLES = 2000
) (
   input logic clk,
   input logic rst_n,
   input logic wip,
   input logic wel,
   input logic mem_we,
   input logic sel,
   input logic byte_valid,
   input logic spi_miso
);
   logic [31:0] busy_len;

   always_ff @(posedge clk) begin
      if (!rst_n)   busy_len <= '0;
      else if (wip) busy_len <= busy_len + 32'd1;
      else          busy_len <= '0;
   end

   // R7: latch stays set for the whole busy window
   p_busy_holds_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wip |-> wel);

   // R7: latch is clear once busy ends
   p_done_clears_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip) |-> !wel);

   // R7: busy window lasts exactly one of the two configured lengths
   p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip) |-> (busy_len == 32'(PROG_CYCLES) || busy_len == 32'(ERASE_CYCLES)));

   // R4: program writes only happen inside a selected transfer
   p_prog_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !wip) |-> sel);

   // R2: latch is only set by a received opcode byte
   p_wel_from_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(byte_valid));

   // R1: output stays low while deselected
   p_miso_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> !spi_miso);
endmodule

bind nf_flash_target nf_flash_target_chk #(
   .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wip(st_wip), .wel(st_wel), .mem_we(m_we),
   .sel(f_sel), .byte_valid(f_valid), .spi_miso(spi_miso)
);

// File: tb/sim_nf_flash_target.sv
module sim_nf_flash_target;
   localparam int AW    = 10;
   localparam int DEPTH = 1 << AW;
   localparam int PG    = 256;
   localparam int SB    = 512;
   localparam int PC    = 200;
   localparam int EC    = 3000;
   localparam int HALF  = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic spi_miso;
   int   total = 0, bad = 0;
   bit   finished = 1'b0;
   logic [7:0] model [DEPTH];

   always #10 clk = ~clk;

   nf_flash_target #(
      .ADDR_W(AW), .PAGE_BYTES(PG), .SECTOR_BYTES(SB),
      .PROG_CYCLES(PC), .ERASE_CYCLES(EC), .SYNC_STAGES(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         spi_mosi = tx[i];
         tick(HALF);
         spi_sck = 1'b1;
         rx[i] = spi_miso;
         tick(HALF);
         spi_sck = 1'b0;
      end
   endtask

   task automatic cs_on();
      spi_cs_n = 1'b0;
      tick(HALF);
   endtask

   task automatic cs_off();
      tick(HALF);
      spi_cs_n = 1'b1;
      tick(8);
   endtask

   task automatic send_addr(input int a);
      logic [7:0] r;
      xfer(8'(a >> 16), r);
      xfer(8'(a >> 8), r);
      xfer(8'(a), r);
   endtask

   task automatic rdsr(output logic [7:0] s);
      logic [7:0] r;
      cs_on();
      xfer(8'h05, r);
      xfer(8'h00, s);
      cs_off();
   endtask

   task automatic wren();
      logic [7:0] r;
      cs_on();
      xfer(8'h06, r);
      cs_off();
   endtask

   task automatic wait_ready();
      logic [7:0] s;
      int n = 0;
      do begin
         rdsr(s);
         n++;
      end while (s[0] && n < 400);
   endtask

   task automatic erase_cmd(input int a);
      logic [7:0] r;
      cs_on();
      xfer(8'hD8, r);
      send_addr(a);
      cs_off();
   endtask

   task automatic erase_model(input int a);
      int base = a & (DEPTH - 1) & ~(SB - 1);
      for (int j = 0; j < SB; j++) model[base + j] = 8'hFF;
   endtask

   task automatic prog(input int a, input int n, input int seed, input bit apply);
      logic [7:0] r, d;
      int idx;
      cs_on();
      xfer(8'h02, r);
      send_addr(a);
      for (int k = 0; k < n; k++) begin
         d = 8'((k * 29 + seed * 7) ^ 8'h5A);
         xfer(d, r);
         if (apply) begin
            idx = ((a & ~(PG - 1)) | ((a + k) & (PG - 1))) & (DEPTH - 1);
            model[idx] = model[idx] & d;
         end
      end
      cs_off();
   endtask

   task automatic read_block(input int a, input int n, input string req);
      logic [7:0] r, d;
      cs_on();
      xfer(8'h03, r);
      send_addr(a);
      for (int k = 0; k < n; k++) begin
         xfer(8'h00, d);
         check(req, d, model[(a + k) & (DEPTH - 1)]);
      end
      cs_off();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] s, r, d;
      int busy_bytes;
      for (int j = 0; j < DEPTH; j++) model[j] = 8'hFF;
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R1: reset state
      check("R1 miso idle", spi_miso, 0);
      rdsr(s);
      check("R1 status after reset", s, 8'h00);

      // R2: write enable sets latch, bit 1
      wren();
      rdsr(s);
      check("R2 status after write enable", s, 8'h02);

      // R6: erase sector 0 (address inside the sector)
      erase_cmd(32'h000100);
      wait_ready();

      // R7: erase sector 1 with high address bits set, time the busy window
      wren();
      erase_cmd(32'h7FF3FF);
      cs_on();
      xfer(8'h05, r);
      busy_bytes = 0;
      for (int k = 0; k < 200; k++) begin
         xfer(8'h00, s);
         if (k == 0) check("R7 status during erase", s, 8'h03);
         if (!s[0]) break;
         busy_bytes++;
      end
      cs_off();
      check("R7 status after erase", s, 8'h00);
      check("R7 busy length in status bytes",
            int'(busy_bytes >= EC / 64 - 3 && busy_bytes <= EC / 64 + 2), 1);

      // R6: whole array erased
      read_block(0, DEPTH, "R6 erased array");

      // R4: program crossing the page end wraps within the page
      wren();
      prog(32'h0001F0, 260, 5, 1'b1);
      wait_ready();
      wren();
      prog(32'h0001FC, 16, 11, 1'b1);
      wait_ready();

      // R5: no latch, program and erase ignored
      prog(32'h000100, 4, 0, 1'b0);
      rdsr(s);
      check("R5 program without latch", s, 8'h00);
      erase_cmd(32'h000000);
      rdsr(s);
      check("R5 erase without latch", s, 8'h00);
      read_block(32'h000100, 256, "R4 R5 page contents");

      // R3: sequential read wrapping at array end
      wren();
      prog(32'h000000, 4, 9, 1'b1);
      wait_ready();
      read_block(32'h0003FC, 8, "R3 read wrap");

      // R8: commands ignored while erase of sector 1 runs
      wren();
      prog(32'h000200, 8, 3, 1'b1);
      wait_ready();
      wren();
      erase_cmd(32'h000200);
      erase_model(32'h000200);
      wren();
      cs_on();
      xfer(8'h03, r);
      send_addr(32'h000000);
      xfer(8'h00, d);
      check("R8 read while busy", d, 8'h00);
      xfer(8'h00, d);
      check("R8 read while busy", d, 8'h00);
      cs_off();
      prog(32'h0001F8, 4, 1, 1'b0);
      rdsr(s);
      check("R8 status while busy", s, 8'h03);
      wait_ready();
      rdsr(s);
      check("R8 write enable while busy ignored", s, 8'h00);
      read_block(32'h0001F8, 16, "R6 R8 sector boundary");

      // R9: unknown opcode
      cs_on();
      xfer(8'h9F, r);
      for (int k = 0; k < 3; k++) begin
         xfer(8'h00, d);
         check("R9 unknown opcode response", d, 8'h00);
      end
      cs_off();
      rdsr(s);
      check("R9 status unchanged", s, 8'h00);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule